// File: doc/BRIEF.md
# Dual-Issue Branch Pairing Checker

This block sits in the issue stage of an in-order core that can issue two instructions per cycle. Each cycle it receives two decoded descriptors in program order: an older slot and a younger slot. Each descriptor lists its source registers with the execute stage that consumes each one, its destination registers with the stage that produces each one, flag read and flag write bits, and a branch-class code. The block decides whether the younger instruction may issue in the same cycle as the older one. It also says whether a load that writes the program counter costs one extra issue cycle, and it gives a reason code when the pair is refused.

Branches follow their own timing model. A conditional branch consumes the flags one stage later than other conditional instructions, so it can pair with a flag-setting older instruction. The program counter is never a data-hazard operand. The only exception is that an instruction reading it cannot pair with one that writes it. All outputs are registered on the issue clock and reflect the descriptors presented one cycle earlier.

Stages are unsigned numbers n that stand for execute stage En. Register index 15 (`PC_IDX`) is the program counter. Branch-class codes are: 0 none, 1 direct, 2 direct-with-link, 3 register-indirect, 4 data-processing write of the PC, 5 load that writes the PC.

Top module: `dual_issue_pairer`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `dualOk`=0, `stallCycles`=0 and `hazardCode`=0.
- R2: Outputs are registered. Descriptors presented before clock edge k are reflected only after edge k, and outputs do not change between edges.
- R3: If either slot is invalid, `dualOk`=0 and `hazardCode`=1 (lone issue).
- R4: A valid younger source that is not register 15 and that names a register an older destination writes is a hazard (code 3) when its need-stage is less than the older produce-stage. An equal or later need-stage pairs.
- R5: Register 15 as a source, or as a destination of the older slot, never causes a register hazard. An older instruction that writes the PC pairs with a younger one that does not read the PC.
- R6: The pair is refused with code 2 when either slot reads register 15 while the other writes the PC. An instruction writes the PC when it lists register 15 as a destination or has a branch class other than 0.
- R7: A younger conditional non-branch instruction (flag read set, branch class 0) also needs each of its own non-PC destination registers as a source at stage E2. Branches do not get this extra source.
- R8: When the older slot writes flags, a younger flag reader with branch class 0 (needs flags at E2) is refused with code 4. A younger flag reader with a branch class other than 0 (needs flags at E3, flags ready at E3) may pair.
- R9: When several hazards apply, the reported code follows the priority lone(1) > PC clash(2) > register(3) > flags(4). `dualOk`=1 only with code 0.
- R10: `stallCycles`=1 when the valid older slot has branch class 5, paired or not, or when the pair is accepted and the younger slot has branch class 5. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Issue clock |
| rst | input | 1 | Synchronous active-high reset |
| oldValid | input | 1 | Older slot holds an instruction |
| oldSrcValid | input | NUM_SRC | Per-source valid, older slot |
| oldSrcReg | input | NUM_SRC*REG_W | Source register indices, older slot |
| oldDstValid | input | NUM_DST | Per-destination valid, older slot |
| oldDstReg | input | NUM_DST*REG_W | Destination register indices, older slot |
| oldDstStage | input | NUM_DST*STAGE_W | Produce stage of each older destination |
| oldFlagWr | input | 1 | Older slot sets the flags |
| oldBrClass | input | 3 | Branch class of the older slot |
| youngValid | input | 1 | Younger slot holds an instruction |
| youngSrcValid | input | NUM_SRC | Per-source valid, younger slot |
| youngSrcReg | input | NUM_SRC*REG_W | Source register indices, younger slot |
| youngSrcStage | input | NUM_SRC*STAGE_W | Need stage of each younger source |
| youngDstValid | input | NUM_DST | Per-destination valid, younger slot |
| youngDstReg | input | NUM_DST*REG_W | Destination register indices, younger slot |
| youngFlagRd | input | 1 | Younger slot is conditional |
| youngBrClass | input | 3 | Branch class of the younger slot |
| dualOk | output | 1 | Both slots may issue this cycle |
| stallCycles | output | 1 | One extra issue cycle for a PC-writing load |
| hazardCode | output | 3 | Refusal reason: 0 none, 1 lone, 2 PC clash, 3 register, 4 flags |

## Verification
The bench builds the block with its default parameters: three sources and two destinations per slot, 4-bit register indices and 3-bit stage fields. Two destinations let one descriptor carry both the link-register write at E3 and the PC write at E4. Three sources allow a PC read, a hazardous operand and a safe operand in one younger instruction, so the priority between PC clash, register hazard and flag hazard can be driven in a single cycle. The 3-bit stage field covers E1 to E4 and the equal-stage boundary of the forwarding rule.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  typedef enum logic [2:0] {
    BR_NONE     = 3'd0,
    BR_DIRECT   = 3'd1,
    BR_LINK     = 3'd2,
    BR_INDIRECT = 3'd3,
    BR_DATAPROC = 3'd4,
    BR_LOAD     = 3'd5
  } brClass_e;

  typedef enum logic [2:0] {
    WHY_NONE = 3'd0,
    WHY_LONE = 3'd1,
    WHY_PC   = 3'd2,
    WHY_REG  = 3'd3,
    WHY_FLAG = 3'd4
  } hazWhy_e;

  // Facts found by the operand matcher, consumed by the decision control
  typedef struct packed {
    logic pcClash;
    logic regRaw;
    logic flagRaw;
    logic oldLoadBr;
    logic youngLoadBr;
  } pairStrobes_t;

endpackage

// File: rtl/dual_issue_match.sv
module dual_issue_match
  import dual_issue_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int REG_W = 4,
  parameter int STAGE_W = 3,
  parameter int PC_IDX = 15,
  parameter int FLAG_READY_STAGE = 3,
  parameter int COND_FLAG_STAGE = 2,
  parameter int BRANCH_FLAG_STAGE = 3,
  parameter int COND_DST_STAGE = 2
) (
  input  logic [NUM_SRC-1:0]         oldSrcValid,
  input  logic [NUM_SRC*REG_W-1:0]   oldSrcReg,
  input  logic [NUM_DST-1:0]         oldDstValid,
  input  logic [NUM_DST*REG_W-1:0]   oldDstReg,
  input  logic [NUM_DST*STAGE_W-1:0] oldDstStage,
  input  logic                       oldFlagWr,
  input  logic [2:0]                 oldBrClass,
  input  logic [NUM_SRC-1:0]         youngSrcValid,
  input  logic [NUM_SRC*REG_W-1:0]   youngSrcReg,
  input  logic [NUM_SRC*STAGE_W-1:0] youngSrcStage,
  input  logic [NUM_DST-1:0]         youngDstValid,
  input  logic [NUM_DST*REG_W-1:0]   youngDstReg,
  input  logic                       youngFlagRd,
  input  logic [2:0]                 youngBrClass,
  output pairStrobes_t               strobes
);

  localparam logic [REG_W-1:0]   PcReg      = REG_W'(PC_IDX);
  localparam logic [STAGE_W-1:0] CondDstStg = STAGE_W'(COND_DST_STAGE);

  logic oldReadsPc, youngReadsPc, oldWritesPc, youngWritesPc;
  logic srcRaw, condRaw, youngCondPlain;

  // PC reads and writes on each slot
  always_comb begin
    oldReadsPc    = 1'b0;
    youngReadsPc  = 1'b0;
    oldWritesPc   = (oldBrClass != BR_NONE);
    youngWritesPc = (youngBrClass != BR_NONE);
    for (int i = 0; i < NUM_SRC; i++) begin
      if (oldSrcValid[i] && oldSrcReg[i*REG_W +: REG_W] == PcReg) oldReadsPc = 1'b1;
      if (youngSrcValid[i] && youngSrcReg[i*REG_W +: REG_W] == PcReg) youngReadsPc = 1'b1;
    end
    for (int j = 0; j < NUM_DST; j++) begin
      if (oldDstValid[j] && oldDstReg[j*REG_W +: REG_W] == PcReg) oldWritesPc = 1'b1;
      if (youngDstValid[j] && youngDstReg[j*REG_W +: REG_W] == PcReg) youngWritesPc = 1'b1;
    end
  end

  // Listed younger sources against older producers
  always_comb begin
    srcRaw = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      for (int j = 0; j < NUM_DST; j++) begin
        if (youngSrcValid[i] && oldDstValid[j]
            && youngSrcReg[i*REG_W +: REG_W] != PcReg
            && youngSrcReg[i*REG_W +: REG_W] == oldDstReg[j*REG_W +: REG_W]
            && youngSrcStage[i*STAGE_W +: STAGE_W] < oldDstStage[j*STAGE_W +: STAGE_W])
          srcRaw = 1'b1;
      end
    end
  end

  // Conditional non-branch: own destinations act as extra sources
  assign youngCondPlain = youngFlagRd && (youngBrClass == BR_NONE);

  always_comb begin
    condRaw = 1'b0;
    for (int k = 0; k < NUM_DST; k++) begin
      for (int j = 0; j < NUM_DST; j++) begin
        if (youngCondPlain && youngDstValid[k] && oldDstValid[j]
            && youngDstReg[k*REG_W +: REG_W] != PcReg
            && youngDstReg[k*REG_W +: REG_W] == oldDstReg[j*REG_W +: REG_W]
            && CondDstStg < oldDstStage[j*STAGE_W +: STAGE_W])
          condRaw = 1'b1;
      end
    end
  end

  localparam int FlagNeedPlain  = COND_FLAG_STAGE;
  localparam int FlagNeedBranch = BRANCH_FLAG_STAGE;

  always_comb begin
    strobes.pcClash = (youngReadsPc && oldWritesPc) || (oldReadsPc && youngWritesPc);
    strobes.regRaw  = srcRaw || condRaw;
    strobes.flagRaw = oldFlagWr && youngFlagRd &&
                      (((youngBrClass == BR_NONE) ? FlagNeedPlain : FlagNeedBranch)
                       < FLAG_READY_STAGE);
    strobes.oldLoadBr   = (oldBrClass == BR_LOAD);
    strobes.youngLoadBr = (youngBrClass == BR_LOAD);
  end

endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dual_issue_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         oldValid,
  input  logic         youngValid,
  input  pairStrobes_t strobes,
  output logic         dualOk,
  output logic         stallCycles,
  output logic [2:0]   hazardCode
);

  logic    nextOk, nextStall;
  hazWhy_e nextWhy;

  always_comb begin
    nextOk  = 1'b0;
    nextWhy = WHY_NONE;
    if (!(oldValid && youngValid))  nextWhy = WHY_LONE;
    else if (strobes.pcClash)       nextWhy = WHY_PC;
    else if (strobes.regRaw)        nextWhy = WHY_REG;
    else if (strobes.flagRaw)       nextWhy = WHY_FLAG;
    else                            nextOk  = 1'b1;
    nextStall = (oldValid && strobes.oldLoadBr) || (nextOk && strobes.youngLoadBr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dualOk      <= 1'b0;
      stallCycles <= 1'b0;
      hazardCode  <= WHY_NONE;
    end else begin
      dualOk      <= nextOk;
      stallCycles <= nextStall;
      hazardCode  <= nextWhy;
    end
  end

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import dual_issue_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int REG_W = 4,
  parameter int STAGE_W = 3,
  parameter int PC_IDX = 15,
  parameter int FLAG_READY_STAGE = 3,
  parameter int COND_FLAG_STAGE = 2,
  parameter int BRANCH_FLAG_STAGE = 3,
  parameter int COND_DST_STAGE = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       oldValid,
  input  logic [NUM_SRC-1:0]         oldSrcValid,
  input  logic [NUM_SRC*REG_W-1:0]   oldSrcReg,
  input  logic [NUM_DST-1:0]         oldDstValid,
  input  logic [NUM_DST*REG_W-1:0]   oldDstReg,
  input  logic [NUM_DST*STAGE_W-1:0] oldDstStage,
  input  logic                       oldFlagWr,
  input  logic [2:0]                 oldBrClass,
  input  logic                       youngValid,
  input  logic [NUM_SRC-1:0]         youngSrcValid,
  input  logic [NUM_SRC*REG_W-1:0]   youngSrcReg,
  input  logic [NUM_SRC*STAGE_W-1:0] youngSrcStage,
  input  logic [NUM_DST-1:0]         youngDstValid,
  input  logic [NUM_DST*REG_W-1:0]   youngDstReg,
  input  logic                       youngFlagRd,
  input  logic [2:0]                 youngBrClass,
  output logic                       dualOk,
  output logic                       stallCycles,
  output logic [2:0]                 hazardCode
);

  pairStrobes_t strobes;

  dual_issue_match #(
    .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .REG_W(REG_W), .STAGE_W(STAGE_W),
    .PC_IDX(PC_IDX), .FLAG_READY_STAGE(FLAG_READY_STAGE),
    .COND_FLAG_STAGE(COND_FLAG_STAGE), .BRANCH_FLAG_STAGE(BRANCH_FLAG_STAGE),
    .COND_DST_STAGE(COND_DST_STAGE)
  ) uMatch (
    .oldSrcValid(oldSrcValid), .oldSrcReg(oldSrcReg),
    .oldDstValid(oldDstValid), .oldDstReg(oldDstReg), .oldDstStage(oldDstStage),
    .oldFlagWr(oldFlagWr), .oldBrClass(oldBrClass),
    .youngSrcValid(youngSrcValid), .youngSrcReg(youngSrcReg), .youngSrcStage(youngSrcStage),
    .youngDstValid(youngDstValid), .youngDstReg(youngDstReg),
    .youngFlagRd(youngFlagRd), .youngBrClass(youngBrClass),
    .strobes(strobes)
  );

  dual_issue_ctrl uCtrl (
    .clk(clk), .rst(rst), .oldValid(oldValid), .youngValid(youngValid),
    .strobes(strobes), .dualOk(dualOk), .stallCycles(stallCycles),
    .hazardCode(hazardCode)
  );

endmodule

// File: rtl/dual_issue_pairer_sva.sv
module dual_issue_pairer_sva #(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int REG_W = 4,
  parameter int STAGE_W = 3,
  parameter int PC_IDX = 15
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       oldValid,
  input logic [NUM_SRC-1:0]         oldSrcValid,
  input logic [NUM_SRC*REG_W-1:0]   oldSrcReg,
  input logic [NUM_DST-1:0]         oldDstValid,
  input logic [NUM_DST*REG_W-1:0]   oldDstReg,
  input logic [NUM_DST*STAGE_W-1:0] oldDstStage,
  input logic                       oldFlagWr,
  input logic [2:0]                 oldBrClass,
  input logic                       youngValid,
  input logic [NUM_SRC-1:0]         youngSrcValid,
  input logic [NUM_SRC*REG_W-1:0]   youngSrcReg,
  input logic [NUM_SRC*STAGE_W-1:0] youngSrcStage,
  input logic [NUM_DST-1:0]         youngDstValid,
  input logic [NUM_DST*REG_W-1:0]   youngDstReg,
  input logic                       youngFlagRd,
  input logic [2:0]                 youngBrClass,
  input logic                       dualOk,
  input logic                       stallCycles,
  input logic [2:0]                 hazardCode
);

  logic bothValid, youngSeesPc;
  assign bothValid = oldValid && youngValid;

  always_comb begin
    youngSeesPc = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (youngSrcValid[i] && youngSrcReg[i*REG_W +: REG_W] == REG_W'(PC_IDX))
        youngSeesPc = 1'b1;
  end

  p_ok_means_clean_r9: assert property (@(posedge clk) disable iff (rst)
    dualOk |-> hazardCode == 3'd0);

  p_lone_refused_r3: assert property (@(posedge clk) disable iff (rst)
    !bothValid |=> (!dualOk && hazardCode == 3'd1));

  p_pc_clash_r6: assert property (@(posedge clk) disable iff (rst)
    (bothValid && youngSeesPc && oldBrClass != 3'd0) |=> hazardCode == 3'd2);

  p_plain_cond_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (bothValid && oldFlagWr && youngFlagRd && youngBrClass == 3'd0) |=> !dualOk);

  p_load_branch_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (oldValid && oldBrClass == 3'd5) |=> stallCycles);

  p_stall_needs_load_r10: assert property (@(posedge clk) disable iff (rst)
    (oldBrClass != 3'd5 && youngBrClass != 3'd5) |=> !stallCycles);

endmodule

bind dual_issue_pairer dual_issue_pairer_sva #(
  .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .REG_W(REG_W),
  .STAGE_W(STAGE_W), .PC_IDX(PC_IDX)
) uSva (.*);

// File: tb/dual_issue_pairer_test.sv
module dual_issue_pairer_test;

  localparam int ClkPeriod = 10;
  localparam int NS = 3;
  localparam int ND = 2;
  localparam int RW = 4;
  localparam int SW = 3;
  localparam int PC = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oldValid, oldFlagWr, youngValid, youngFlagRd;
  logic [NS-1:0] oldSrcValid, youngSrcValid;
  logic [NS*RW-1:0] oldSrcReg, youngSrcReg;
  logic [NS*SW-1:0] youngSrcStage;
  logic [ND-1:0] oldDstValid, youngDstValid;
  logic [ND*RW-1:0] oldDstReg, youngDstReg;
  logic [ND*SW-1:0] oldDstStage;
  logic [2:0] oldBrClass, youngBrClass;
  logic dualOk, stallCycles;
  logic [2:0] hazardCode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  dual_issue_pairer uut (
    .clk(clk), .rst(rst),
    .oldValid(oldValid), .oldSrcValid(oldSrcValid), .oldSrcReg(oldSrcReg),
    .oldDstValid(oldDstValid), .oldDstReg(oldDstReg), .oldDstStage(oldDstStage),
    .oldFlagWr(oldFlagWr), .oldBrClass(oldBrClass),
    .youngValid(youngValid), .youngSrcValid(youngSrcValid), .youngSrcReg(youngSrcReg),
    .youngSrcStage(youngSrcStage), .youngDstValid(youngDstValid),
    .youngDstReg(youngDstReg), .youngFlagRd(youngFlagRd), .youngBrClass(youngBrClass),
    .dualOk(dualOk), .stallCycles(stallCycles), .hazardCode(hazardCode)
  );

  task automatic clearSlots();
    oldValid = 1'b1; youngValid = 1'b1;
    oldSrcValid = '0; oldSrcReg = '0; oldDstValid = '0; oldDstReg = '0; oldDstStage = '0;
    oldFlagWr = 1'b0; oldBrClass = 3'd0;
    youngSrcValid = '0; youngSrcReg = '0; youngSrcStage = '0;
    youngDstValid = '0; youngDstReg = '0; youngFlagRd = 1'b0; youngBrClass = 3'd0;
  endtask

  task automatic oldSrc(int idx, int r);
    oldSrcValid[idx] = 1'b1; oldSrcReg[idx*RW +: RW] = RW'(r);
  endtask
  task automatic oldDst(int idx, int r, int stg);
    oldDstValid[idx] = 1'b1; oldDstReg[idx*RW +: RW] = RW'(r);
    oldDstStage[idx*SW +: SW] = SW'(stg);
  endtask
  task automatic youngSrc(int idx, int r, int stg);
    youngSrcValid[idx] = 1'b1; youngSrcReg[idx*RW +: RW] = RW'(r);
    youngSrcStage[idx*SW +: SW] = SW'(stg);
  endtask
  task automatic youngDst(int idx, int r);
    youngDstValid[idx] = 1'b1; youngDstReg[idx*RW +: RW] = RW'(r);
  endtask

  task automatic compare(string tag, logic expOk, logic expStall, logic [2:0] expCode);
    checks++;
    if (dualOk !== expOk || stallCycles !== expStall || hazardCode !== expCode) begin
      fails++;
      $display("FAIL %s: got ok=%0b stall=%0b code=%0d, expected ok=%0b stall=%0b code=%0d",
               tag, dualOk, stallCycles, hazardCode, expOk, expStall, expCode);
    end
  endtask

  // inputs are already set on a falling edge; one rising edge registers them
  task automatic settle(string tag, logic expOk, logic expStall, logic [2:0] expCode);
    @(posedge clk);
    @(negedge clk);
    compare(tag, expOk, expStall, expCode);
  endtask

  task automatic testReset();
    compare("R1 reset state", 1'b0, 1'b0, 3'd0);
  endtask

  task automatic testLone();
    clearSlots(); youngValid = 1'b0;
    settle("R3 younger slot empty", 1'b0, 1'b0, 3'd1);
    clearSlots(); youngValid = 1'b0; oldBrClass = 3'd5; oldDst(0, PC, 4);
    settle("R10 lone PC load stalls", 1'b0, 1'b1, 3'd1);
    clearSlots(); oldValid = 1'b0;
    settle("R3 older slot empty", 1'b0, 1'b0, 3'd1);
  endtask

  task automatic testRegRaw();
    clearSlots(); oldDst(0, 1, 3); youngSrc(0, 4, 2);
    settle("R4 independent pair", 1'b1, 1'b0, 3'd0);
    clearSlots(); oldDst(0, 1, 3); youngSrc(1, 1, 2);
    settle("R4 needed before produced", 1'b0, 1'b0, 3'd3);
    clearSlots(); oldDst(0, 1, 3); youngSrc(1, 1, 3);
    settle("R4 needed at produce stage", 1'b1, 1'b0, 3'd0);
    clearSlots(); oldDst(1, 6, 4); youngSrc(2, 6, 3);
    settle("R4 second destination", 1'b0, 1'b0, 3'd3);
  endtask

  task automatic testPcExempt();
    clearSlots(); oldDst(0, 14, 3); youngSrc(0, PC, 1);
    settle("R5 younger reads PC, older no PC write", 1'b1, 1'b0, 3'd0);
    clearSlots(); oldBrClass = 3'd4; oldDst(0, PC, 4); youngSrc(0, 5, 1);
    settle("R5 PC write no hazard to later op", 1'b1, 1'b0, 3'd0);
  endtask

  task automatic testPcClash();
    clearSlots(); oldBrClass = 3'd1; youngSrc(0, PC, 2);
    settle("R6 branch then PC reader", 1'b0, 1'b0, 3'd2);
    clearSlots(); oldSrc(2, PC); youngDst(0, PC);
    settle("R6 PC reader then PC writer", 1'b0, 1'b0, 3'd2);
    clearSlots(); oldBrClass = 3'd2; oldDst(0, 14, 3); oldDst(1, PC, 4); youngSrc(0, 14, 3);
    settle("R6 link branch alone is no clash", 1'b1, 1'b0, 3'd0);
  endtask

  task automatic testCondDst();
    clearSlots(); oldDst(0, 2, 3); youngFlagRd = 1'b1; youngDst(0, 2);
    settle("R7 conditional own dest as source", 1'b0, 1'b0, 3'd3);
    clearSlots(); oldDst(0, 2, 3); youngDst(0, 2);
    settle("R7 unconditional dest only", 1'b1, 1'b0, 3'd0);
    clearSlots(); oldDst(0, 2, 3); youngFlagRd = 1'b1; youngBrClass = 3'd4;
    youngDst(0, PC); youngDst(1, 2);
    settle("R7 branch gets no extra source", 1'b1, 1'b0, 3'd0);
  endtask

  task automatic testFlags();
    clearSlots(); oldFlagWr = 1'b1; youngFlagRd = 1'b1;
    settle("R8 flag setter then plain conditional", 1'b0, 1'b0, 3'd4);
    clearSlots(); oldFlagWr = 1'b1; youngFlagRd = 1'b1; youngBrClass = 3'd1;
    settle("R8 flag setter then conditional branch", 1'b1, 1'b0, 3'd0);
  endtask

  task automatic testPriority();
    clearSlots(); oldBrClass = 3'd4; oldDst(0, PC, 4); oldDst(1, 3, 3); oldFlagWr = 1'b1;
    youngSrc(0, PC, 1); youngSrc(1, 3, 1); youngFlagRd = 1'b1;
    settle("R9 PC clash wins", 1'b0, 1'b0, 3'd2);
    clearSlots(); oldDst(1, 3, 3); oldFlagWr = 1'b1; youngSrc(1, 3, 1); youngFlagRd = 1'b1;
    settle("R9 register beats flags", 1'b0, 1'b0, 3'd3);
  endtask

  task automatic testStall();
    clearSlots(); youngBrClass = 3'd5; youngSrc(0, 7, 2);
    settle("R10 paired younger PC load", 1'b1, 1'b1, 3'd0);
    clearSlots(); oldDst(0, 7, 3); youngBrClass = 3'd5; youngSrc(0, 7, 2);
    settle("R10 refused younger PC load", 1'b0, 1'b0, 3'd3);
    clearSlots(); oldBrClass = 3'd5; oldDst(0, PC, 4); youngSrc(0, PC, 1);
    settle("R10 older PC load refused pair", 1'b0, 1'b1, 3'd2);
  endtask

  task automatic testLatency();
    clearSlots(); oldDst(0, 8, 3); youngSrc(0, 8, 1);
    settle("R2 first pattern", 1'b0, 1'b0, 3'd3);
    clearSlots();
    #1 compare("R2 holds until edge", 1'b0, 1'b0, 3'd3);
    settle("R2 after edge", 1'b1, 1'b0, 3'd0);
  endtask

  initial begin
    #(ClkPeriod * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    clearSlots();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    testLone();
    testRegRaw();
    testPcExempt();
    testPcClash();
    testCondDst();
    testFlags();
    testPriority();
    testStall();
    testLatency();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule